// File: doc/BRIEF.md
# Serial Line Transmitter with Line Control

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding register. The block moves the byte into a shift stage and sends it on a single output line as a frame. The frame holds a start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one, one and a half or two stop bits. The line rests at logic 1 between frames.

A line control register sets the frame format. It also holds a break control that pulls the line low, and a latch-select bit. When the latch-select bit is set, the two lowest write offsets load a 16-bit baud divisor in place of the data path. The bit time is sixteen ticks of a divided clock, so the baud rate is the clock rate divided by sixteen times the divisor.

Two flags let software pace its writes. The first says the holding register can take a byte. The second says both the holding register and the shift stage are empty, which means the line has gone quiet.

Top module: `uart_line_tx`

## Requirements
- R1: After reset, txd is 1, thr_empty is 1, tx_empty is 1, the divisor is 0 and every line control bit is 0. While tx_empty is 1 and break is off, txd is 1.
- R2: A write to offset 3 loads the line control register. Bits 1:0 set the word length (0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8). Bit 2 sets the stop bits, bit 3 enables parity, bit 4 selects even parity, bit 5 selects stick parity, bit 6 is break and bit 7 is latch-select.
- R3: With bit 7 set, a write to offset 0 loads divisor bits 7:0 and a write to offset 1 loads divisor bits 15:8, and the holding register is untouched. With bit 7 clear, offset 0 writes the holding register and offset 1 writes are ignored.
- R4: One bit time lasts 16 × divisor clock cycles. A divisor of 0 stops the baud tick, so no frame starts and txd stays still.
- R5: A frame is a 0 start bit, then the word-length data bits of the byte, least significant bit first.
- R6: Parity follows bits 5:3 (stick, even, enable). With enable at 0 no parity bit is sent. Enable alone gives odd parity. Enable with even gives even parity. Enable with stick gives a constant 1. Enable with stick and even gives a constant 0.
- R7: With bit 2 clear there is one stop bit. With bit 2 set there are two stop bits, or one and a half for a 5-bit word. Each stop bit is a 1, and tx_empty rises exactly when the last stop bit ends.
- R8: While break is set, txd is 0. Frame timing runs on underneath, so a frame ends at its normal time.
- R9: A data write clears thr_empty. thr_empty is set again in the cycle the start bit of that byte begins.
- R10: tx_empty is 1 only while the holding register and the shift stage are both empty.
- R11: A byte waiting in the holding register starts with its start bit directly after the previous frame's last stop bit, with no idle time between.
- R12: The frame format is taken when a frame starts. Line control writes during a frame apply from the next frame on, except for break.
- R13: A data write while the holding register is full replaces the waiting byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial output, idles at 1 |
| thr_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
The bound checker watches a set of per-cycle rules. Break takes the line low on the cycle after the write. A data write clears the holding flag. Writes with latch-select set leave that flag alone. The all-empty flag always implies the holding flag. With a zero divisor and no writes, the line and the flag stay frozen. Frame contents, parity values, exact bit and stop lengths, back-to-back spacing and the point at which format changes take effect need whole frames to judge. The bench covers these by sweeping every word length, stop setting and parity mode at two divisors and sampling each bit at its centre.

// File: rtl/uart_line_pkg.sv
package uart_line_pkg;

   typedef enum logic [2:0] {
      TX_IDLE   = 3'd0,
      TX_START  = 3'd1,
      TX_DATA   = 3'd2,
      TX_PARITY = 3'd3,
      TX_STOP   = 3'd4
   } tx_state_t;

   // line control layout, most significant field first
   typedef struct packed {
      logic       dlab;
      logic       brk;
      logic       stick;
      logic       even;
      logic       par_en;
      logic       stop2;
      logic [1:0] wlen;
   } line_ctrl_t;

   localparam logic [2:0] OFS_DATA_LO = 3'd0;
   localparam logic [2:0] OFS_DIV_HI  = 3'd1;
   localparam logic [2:0] OFS_LINE    = 3'd3;

   // parity bit for the active word length
   function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] wlen,
                                        input logic even, input logic stick);
      logic [7:0] mask;
      logic       odd_ones;
      mask     = 8'hFF >> (2'd3 - wlen);
      odd_ones = ^(d & mask);
      if (stick) return ~even;
      return even ? odd_ones : ~odd_ones;
   endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (divisor != '0) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (divisor == '0)    cnt_q <= '0;
      else if (tick)             cnt_q <= divisor - 1'b1;
      else                       cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/uart_frame_shifter.sv
module uart_frame_shifter
   import uart_line_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       hold_full,
   input  logic [7:0] hold_data,
   input  logic [1:0] wlen,
   input  logic       stop2,
   input  logic       par_en,
   input  logic       even,
   input  logic       stick,
   output logic       load,
   output logic       line,
   output logic       busy
);
   localparam int CNT_W = $clog2(2 * OVERSAMPLE);
   localparam logic [CNT_W-1:0] LEN_BIT  = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] LEN_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] LEN_TWO  = CNT_W'(2 * OVERSAMPLE - 1);

   tx_state_t        state_q;
   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] stop_len_q;
   logic [7:0]       sh_q;
   logic [2:0]       bits_q;
   logic             par_q;
   logic             pen_q;
   logic [CNT_W-1:0] stop_len_d;

   always_comb begin
      if (!stop2)             stop_len_d = LEN_BIT;
      else if (wlen == 2'd0)  stop_len_d = LEN_HALF;
      else                    stop_len_d = LEN_TWO;
   end

   assign load = tick && hold_full &&
                 ((state_q == TX_IDLE) || (state_q == TX_STOP && left_q == '0));
   assign busy = (state_q != TX_IDLE);

   always_comb begin
      unique case (state_q)
         TX_START:  line = 1'b0;
         TX_DATA:   line = sh_q[0];
         TX_PARITY: line = par_q;
         default:   line = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TX_IDLE;
         left_q     <= '0;
         stop_len_q <= LEN_BIT;
         sh_q       <= '0;
         bits_q     <= '0;
         par_q      <= 1'b0;
         pen_q      <= 1'b0;
      end else if (load) begin
         state_q    <= TX_START;
         left_q     <= LEN_BIT;
         stop_len_q <= stop_len_d;
         sh_q       <= hold_data;
         bits_q     <= 3'(wlen) + 3'd4;
         par_q      <= calc_parity(hold_data, wlen, even, stick);
         pen_q      <= par_en;
      end else if (tick) begin
         if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end else begin
            unique case (state_q)
               TX_START: begin
                  state_q <= TX_DATA;
                  left_q  <= LEN_BIT;
               end
               TX_DATA: begin
                  if (bits_q == '0) begin
                     state_q <= pen_q ? TX_PARITY : TX_STOP;
                     left_q  <= pen_q ? LEN_BIT : stop_len_q;
                  end else begin
                     sh_q   <= {1'b0, sh_q[7:1]};
                     bits_q <= bits_q - 1'b1;
                     left_q <= LEN_BIT;
                  end
               end
               TX_PARITY: begin
                  state_q <= TX_STOP;
                  left_q  <= stop_len_q;
               end
               TX_STOP:  state_q <= TX_IDLE;
               default:  state_q <= TX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx
   import uart_line_pkg::*;
#(
   parameter int DIV_W      = 16,
   parameter int OVERSAMPLE = 16,
   parameter int ADDR_W     = 3,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              txd,
   output logic              thr_empty,
   output logic              tx_empty
);
   initial begin
      if (DIV_W <= 8 || DIV_W > 16) $error("DIV_W must lie in 9..16");
      if (OVERSAMPLE < 2 || (OVERSAMPLE % 2) != 0) $error("OVERSAMPLE must be even and at least 2");
      if (ADDR_W < 2) $error("ADDR_W must be at least 2");
   end

   line_ctrl_t       lcr_q;
   logic [DIV_W-1:0] div_q;
   logic [7:0]       hold_q;
   logic             hold_full_q;
   logic             dlab_on;
   logic             brk_on;
   logic             tick;
   logic             load;
   logic             line;
   logic             busy;
   logic             wr_lo;
   logic             wr_hi;
   logic             wr_line;

   assign dlab_on = lcr_q.dlab;
   assign brk_on  = lcr_q.brk;
   assign wr_lo   = wr_en && (wr_addr == ADDR_W'(OFS_DATA_LO));
   assign wr_hi   = wr_en && (wr_addr == ADDR_W'(OFS_DIV_HI));
   assign wr_line = wr_en && (wr_addr == ADDR_W'(OFS_LINE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q       <= '0;
         div_q       <= '0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else begin
         if (wr_line) lcr_q <= line_ctrl_t'(wr_data);
         if (wr_lo && dlab_on) div_q[7:0] <= wr_data;
         if (wr_hi && dlab_on) div_q[DIV_W-1:8] <= wr_data[DIV_W-9:0];
         if (wr_lo && !dlab_on) begin
            hold_q      <= wr_data;
            hold_full_q <= 1'b1;
         end else if (load) begin
            hold_full_q <= 1'b0;
         end
      end
   end

   uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (div_q),
      .tick    (tick)
   );

   uart_frame_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .hold_full (hold_full_q),
      .hold_data (hold_q),
      .wlen      (lcr_q.wlen),
      .stop2     (lcr_q.stop2),
      .par_en    (lcr_q.par_en),
      .even      (lcr_q.even),
      .stick     (lcr_q.stick),
      .load      (load),
      .line      (line),
      .busy      (busy)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         logic txd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) txd_q <= 1'b1;
            else        txd_q <= brk_on ? 1'b0 : line;
         end
         assign txd = txd_q;
      end else begin : g_comb_out
         assign txd = brk_on ? 1'b0 : line;
      end
   endgenerate

   assign thr_empty = ~hold_full_q;
   assign tx_empty  = ~hold_full_q & ~busy;
endmodule

// File: rtl/uart_line_tx_chk.sv
module uart_line_tx_chk #(
   parameter int DIV_W   = 16,
   parameter int ADDR_W  = 3,
   parameter bit REG_OUT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              txd,
   input logic              thr_empty,
   input logic              tx_empty,
   input logic              dlab,
   input logic              brk,
   input logic [DIV_W-1:0]  divisor
);
   logic data_wr;
   logic line_wr_brk;
   assign data_wr     = wr_en && (wr_addr == ADDR_W'(0));
   assign line_wr_brk = wr_en && (wr_addr == ADDR_W'(3)) && wr_data[6];

   assert_thr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && !dlab |=> !thr_empty);

   assert_dlab_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && dlab && thr_empty |=> thr_empty);

   assert_empty_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> thr_empty);

   generate
      if (!REG_OUT) begin : g_comb_checks
         assert_brk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            line_wr_brk |=> !txd);

         assert_div_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (divisor == '0) && !wr_en |=> $stable(txd) && $stable(thr_empty));

         assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
            tx_empty && !brk |-> txd);
      end else begin : g_reg_checks
         assert_brk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            line_wr_brk |=> ##1 !txd);
      end
   endgenerate
endmodule

bind uart_line_tx uart_line_tx_chk #(
   .DIV_W   (DIV_W),
   .ADDR_W  (ADDR_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .txd       (txd),
   .thr_empty (thr_empty),
   .tx_empty  (tx_empty),
   .dlab      (dlab_on),
   .brk       (brk_on),
   .divisor   (div_q)
);

// File: tb/test_uart_line_tx.sv
module test_uart_line_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       txd;
   logic       thr_empty;
   logic       tx_empty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_line_tx i_uart_line_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .txd       (txd),
      .thr_empty (thr_empty),
      .tx_empty  (tx_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_start();
      int t = 0;
      while (txd === 1'b1 && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(txd === 1'b0, "R5 start bit seen", int'(txd), 0);
   endtask

   function automatic logic exp_parity(input logic [7:0] d, input int w, input logic [7:0] lcr);
      int ones = 0;
      for (int i = 0; i < w; i++) ones += d[i];
      if (lcr[5]) return ~lcr[4];
      if (lcr[4]) return logic'(ones % 2);
      return logic'((ones % 2) == 0);
   endfunction

   // called at the negedge where the start bit is first visible
   task automatic check_frame(input logic [7:0] d, input logic [7:0] lcr, input int dv,
                              input int a, input logic [2:0] a_addr, input logic [7:0] a_data,
                              input int b, input logic [7:0] b_data, input bit end_idle);
      int w     = int'(lcr[1:0]) + 5;
      int p     = int'(lcr[3]);
      int s     = 1 + w + p;
      int sl    = !lcr[2] ? 16 : (w == 5 ? 24 : 32);
      int n_end = dv * (16 * s + sl);
      for (int n = 0; n <= n_end; n++) begin
         int  m;
         bit  smp;
         bit  brk;
         logic e;
         if (n > 0) @(negedge clk);
         wr_en = 1'b0;
         if (n == a) begin
            wr_en = 1'b1; wr_addr = a_addr; wr_data = a_data;
         end else if (n == b) begin
            wr_en = 1'b1; wr_addr = 3'd3; wr_data = b_data;
         end
         m   = n / dv;
         smp = (n % dv == 0) && (n < n_end) &&
               ((m % 16 == 8) || (sl == 24 && m == 16 * s + 20));
         brk = (a >= 0) && (a_addr == 3'd3) && a_data[6] && (n > a) && (b < 0 || n <= b);
         if (smp) begin
            int k = m / 16;
            if (k == 0)       e = 1'b0;
            else if (k <= w)  e = d[k-1];
            else if (k < s)   e = exp_parity(d, w, lcr);
            else              e = 1'b1;
            if (brk) e = 1'b0;
            if (brk)          chk(txd === e, "R8 break holds line low", int'(txd), int'(e));
            else if (k == 0)  chk(txd === e, "R5 start bit", int'(txd), int'(e));
            else if (k <= w)  chk(txd === e, "R5 data bit", int'(txd), int'(e));
            else if (k < s)   chk(txd === e, "R6 parity bit", int'(txd), int'(e));
            else              chk(txd === e, "R7 stop bit", int'(txd), int'(e));
         end
         if (n == n_end - 1)
            chk(tx_empty === 1'b0, "R7 busy until last stop ends", int'(tx_empty), 0);
         if (n == n_end)
            chk(tx_empty === end_idle, "R7 R10 tx_empty at frame end", int'(tx_empty), int'(end_idle));
      end
      wr_en = 1'b0;
   endtask

   task automatic setup(input logic [7:0] lcr, input logic [15:0] dv);
      wr_reg(3'd3, lcr | 8'h80);
      wr_reg(3'd0, dv[7:0]);
      wr_reg(3'd1, dv[15:8]);
      wr_reg(3'd3, lcr);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
      chk(thr_empty === 1'b1, "R1 thr_empty", int'(thr_empty), 1);
      chk(tx_empty === 1'b1, "R1 tx_empty", int'(tx_empty), 1);

      // R4 zero divisor freezes; R9 R10 flags; R13 overwrite
      wr_reg(3'd0, 8'h3C);
      repeat (100) @(negedge clk);
      chk(txd === 1'b1, "R4 zero divisor no frame", int'(txd), 1);
      chk(thr_empty === 1'b0, "R9 data write clears thr_empty", int'(thr_empty), 0);
      chk(tx_empty === 1'b0, "R10 tx_empty low while holding", int'(tx_empty), 0);
      wr_reg(3'd0, 8'hB5);
      wr_reg(3'd3, 8'h83);
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd0, 8'h01);
      wait_start();
      chk(thr_empty === 1'b1, "R9 thr_empty set at start", int'(thr_empty), 1);
      // R13: frame carries the replacing byte; R12 line write mid-frame
      check_frame(8'hB5, 8'h03, 1, 1, 3'd3, 8'h03, -1, 8'h00, 1'b1);

      // R3 latch-select routes offset 0 to the divisor
      wr_reg(3'd3, 8'h83);
      wr_reg(3'd0, 8'h02);
      repeat (60) @(negedge clk);
      chk(thr_empty === 1'b1, "R3 dlab write leaves holding empty", int'(thr_empty), 1);
      chk(txd === 1'b1, "R3 dlab write sends nothing", int'(txd), 1);
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd3, 8'h03);
      wr_reg(3'd1, 8'h07);   // ignored with latch-select clear
      wr_reg(3'd0, 8'hC3);
      wait_start();
      check_frame(8'hC3, 8'h03, 2, -1, 3'd0, 8'h00, -1, 8'h00, 1'b1);

      // R2 R5 R6 R7 R4 sweep over formats at two divisors
      for (int di = 0; di < 2; di++) begin
         int dv = (di == 0) ? 1 : 3;
         for (int wl = 0; wl < 4; wl++) begin
            for (int st = 0; st < 2; st++) begin
               for (int pm = 0; pm < 5; pm++) begin
                  logic [7:0] lcr;
                  logic [7:0] d;
                  logic [7:0] pbits;
                  case (pm)
                     0: pbits = 8'h00;
                     1: pbits = 8'h08;
                     2: pbits = 8'h18;
                     3: pbits = 8'h28;
                     default: pbits = 8'h38;
                  endcase
                  lcr = 8'(wl) | 8'(st << 2) | pbits;
                  d   = 8'h5A ^ 8'((wl * 10 + st * 5 + pm) * 37);
                  setup(lcr, 16'(dv));
                  wr_reg(3'd0, d);
                  wait_start();
                  check_frame(d, lcr, dv, -1, 3'd0, 8'h00, -1, 8'h00, 1'b1);
               end
            end
         end
      end

      // R8 break mid-frame, timing unchanged
      setup(8'h1B, 16'd1);
      wr_reg(3'd0, 8'h96);
      wait_start();
      check_frame(8'h96, 8'h1B, 1, 40, 3'd3, 8'h5B, 90, 8'h1B, 1'b1);
      // R8 break while idle
      wr_reg(3'd3, 8'h43);
      @(negedge clk);
      chk(txd === 1'b0, "R8 break while idle", int'(txd), 0);
      wr_reg(3'd3, 8'h03);
      chk(txd === 1'b1, "R8 break released", int'(txd), 1);

      // R12 format change mid-frame takes effect next frame
      wr_reg(3'd0, 8'hA5);
      wait_start();
      check_frame(8'hA5, 8'h03, 1, 30, 3'd3, 8'h0C, -1, 8'h00, 1'b1);
      wr_reg(3'd0, 8'h3C);
      wait_start();
      check_frame(8'h3C, 8'h0C, 1, -1, 3'd0, 8'h00, -1, 8'h00, 1'b1);

      // R11 back-to-back frames
      wr_reg(3'd3, 8'h03);
      wr_reg(3'd0, 8'h11);
      wait_start();
      check_frame(8'h11, 8'h03, 1, 20, 3'd0, 8'h22, -1, 8'h00, 1'b0);
      chk(txd === 1'b0, "R11 next start bit follows at once", int'(txd), 0);
      chk(thr_empty === 1'b1, "R11 waiting byte taken", int'(thr_empty), 1);
      check_frame(8'h22, 8'h03, 1, -1, 3'd0, 8'h00, -1, 8'h00, 1'b1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule